// File: doc/BRIEF.md
# Stereo Framebuffer Scan Address Generator

This block sits on the display side of a chip. It hands the memory fetch unit one line-start address per scanline of a panel refresh. A configuration word set drives its inputs: frame dimensions, two address pairs (eye A and eye B, each with a buffer 0 and a buffer 1), a buffer-select bit, a row stride and a format word. A one-cycle frame-start strobe captures all of this. Later changes to the inputs therefore cannot tear a frame that is being scanned.

After the capture, each line-advance strobe makes the block offer that scanline's start address on a valid/ready port. In stereo mode the block offers two beats per scanline, eye A first and then eye B. In mono mode it offers a single beat. When the two selected eye addresses differ, that beat takes eye A and eye B on alternate frames. Once the captured number of lines has been delivered, the block idles until the next frame start. It also presents the captured color format, frame width, full format word and a stereo-enable flag.

The controller has four states. `ST_IDLE` is the state after reset, after the last line of a frame, or after a zero-height frame start. `ST_WAIT` waits for a line-advance. `ST_BEAT_A` offers the first beat and `ST_BEAT_B` offers the eye-B beat.

The transitions are as follows. From `ST_WAIT`, a line-advance moves the controller to `ST_BEAT_A`. From `ST_BEAT_A`, a handshake moves it to `ST_BEAT_B` in stereo mode. In mono mode it moves to `ST_WAIT`, or to `ST_IDLE` after the last line. From `ST_BEAT_B`, a handshake moves it to `ST_WAIT`, or to `ST_IDLE` after the last line. A frame start from any state moves it to `ST_WAIT`, or to `ST_IDLE` if the height is zero.

Top module: `stereo_scan_gen`

## Requirements
- R1: After reset, `line_valid`, `stereo_en`, `color_fmt`, `act_width` and `act_fmt` are all zero, and no beat is offered until a frame start and a line-advance occur.
- R2: Configuration inputs are captured only in the cycle `frame_start` is high. Changing them at any other time has no effect on the addresses, eyes, or any output of the current frame.
- R3: `cfg_buf_sel` = 0 selects `cfg_a0`/`cfg_b0` as the eye A/B bases; `cfg_buf_sel` = 1 selects `cfg_a1`/`cfg_b1`.
- R4: The beat for scanline n (counting from 0) carries the address base + n × stride modulo 2^32. The stride used is `cfg_stride` with its bits 2:0 forced to zero.
- R5: `cfg_dims` holds the width in bits 15:0 and the height H in bits 31:16. The block serves exactly H scanlines per frame, one per line-advance accepted in `ST_WAIT`. A line-advance while a beat is pending, or after the last line, is ignored. H = 0 yields no beats.
- R6: `stereo_en` is 1 exactly when the captured format word has bit 5 = 1 and bit 6 = 0.
- R7: In stereo mode each scanline gives two beats: the eye-A base with `line_eye` = 0, then the eye-B base with `line_eye` = 1.
- R8: In mono mode each scanline gives one beat. If the selected A and B bases are equal, it uses base A with `line_eye` = 0. If they differ, it uses A (eye 0) when an even number of frame starts preceded this one since reset, and B (eye 1) otherwise.
- R9: While `line_valid` is high and `line_ready` is low, `line_valid`, `line_addr` and `line_eye` hold their values to the next cycle, unless `frame_start` is high.
- R10: `frame_start` takes priority in every state. It abandons the current frame and drops `line_valid` in the next cycle. It restarts at scanline 0, and a line-advance in the same cycle is ignored.
- R11: `color_fmt` equals bits 2:0 of the captured format word (0 RGBA8888, 1 RGB888, 2 RGB565, 3 RGB5551, 4 RGBA4444). `act_fmt` equals the whole captured word, and `act_width` equals the captured width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start strobe; captures configuration |
| line_adv | input | 1 | Line-advance strobe |
| cfg_dims | input | 32 | Height in 31:16, width in 15:0 |
| cfg_a0 | input | 32 | Eye A, buffer 0 base |
| cfg_a1 | input | 32 | Eye A, buffer 1 base |
| cfg_b0 | input | 32 | Eye B, buffer 0 base |
| cfg_b1 | input | 32 | Eye B, buffer 1 base |
| cfg_buf_sel | input | 1 | Buffer select |
| cfg_stride | input | 32 | Row stride in bytes |
| cfg_fmt | input | 16 | Format word |
| line_ready | input | 1 | Consumer accepts the beat |
| line_valid | output | 1 | Beat offered |
| line_addr | output | 32 | Line-start address |
| line_eye | output | 1 | 0 = eye A, 1 = eye B |
| color_fmt | output | 3 | Captured color format |
| stereo_en | output | 1 | Stereo output enabled |
| act_width | output | 16 | Captured frame width |
| act_fmt | output | 16 | Captured format word |

## Verification
Two collisions matter. In the first, a frame start arrives in the same cycle as a line-advance. In the second, a frame start arrives while a beat is stalled by a low ready. The bench provokes both with a directed case that raises `frame_start`, `line_adv` and a new configuration together while the eye-A beat is held. It then expects `line_valid` low in the next cycle and scanline 0 of the new configuration on the following advance. The random frames also toggle `line_adv` on every cycle a beat is pending, including the cycle of the final handshake. For each of these cycles, the bench requires that no extra scanline appears.

// File: rtl/ssag_pkg.sv
package ssag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_BEAT_A = 2'd2,
        ST_BEAT_B = 2'd3
    } scan_state_t;
endpackage

// File: rtl/ssag_frame_latch.sv
module ssag_frame_latch #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16,
    parameter int FMT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [2*DIM_W-1:0] cfg_dims,
    input  logic [ADDR_W-1:0]  cfg_a0,
    input  logic [ADDR_W-1:0]  cfg_a1,
    input  logic [ADDR_W-1:0]  cfg_b0,
    input  logic [ADDR_W-1:0]  cfg_b1,
    input  logic               cfg_buf_sel,
    input  logic [ADDR_W-1:0]  cfg_stride,
    input  logic [FMT_W-1:0]   cfg_fmt,
    output logic [ADDR_W-1:0]  base_a,
    output logic [ADDR_W-1:0]  base_b,
    output logic [ADDR_W-1:0]  stride,
    output logic [DIM_W-1:0]   height,
    output logic [DIM_W-1:0]   width,
    output logic [FMT_W-1:0]   fmt,
    output logic               stereo,
    output logic               mono_eye
);
    localparam logic [ADDR_W-1:0] STRIDE_MASK = {{(ADDR_W-3){1'b1}}, 3'b000};

    logic [ADDR_W-1:0] pick_a, pick_b;
    logic              parity_q;

    always_comb begin
        pick_a = cfg_buf_sel ? cfg_a1 : cfg_a0;
        pick_b = cfg_buf_sel ? cfg_b1 : cfg_b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_a   <= '0;
            base_b   <= '0;
            stride   <= '0;
            height   <= '0;
            width    <= '0;
            fmt      <= '0;
            stereo   <= 1'b0;
            mono_eye <= 1'b0;
            parity_q <= 1'b0;
        end else if (capture) begin
            base_a   <= pick_a;
            base_b   <= pick_b;
            stride   <= cfg_stride & STRIDE_MASK;
            height   <= cfg_dims[2*DIM_W-1:DIM_W];
            width    <= cfg_dims[DIM_W-1:0];
            fmt      <= cfg_fmt;
            stereo   <= cfg_fmt[5] & ~cfg_fmt[6];
            mono_eye <= (pick_a != pick_b) & parity_q;
            parity_q <= ~parity_q;
        end
    end
endmodule

// File: rtl/ssag_line_ctr.sv
module ssag_line_ctr #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [ADDR_W-1:0] stride,
    input  logic [DIM_W-1:0]  height,
    output logic [ADDR_W-1:0] row_off,
    output logic              last_line
);
    logic [DIM_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            row_off <= '0;
        end else if (step) begin
            cnt_q   <= cnt_q + DIM_W'(1);
            row_off <= row_off + stride;
        end
    end

    assign last_line = (cnt_q == height - DIM_W'(1));
endmodule

// File: rtl/stereo_scan_gen.sv
module stereo_scan_gen
    import ssag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16,
    parameter int FMT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_adv,
    input  logic [2*DIM_W-1:0] cfg_dims,
    input  logic [ADDR_W-1:0]  cfg_a0,
    input  logic [ADDR_W-1:0]  cfg_a1,
    input  logic [ADDR_W-1:0]  cfg_b0,
    input  logic [ADDR_W-1:0]  cfg_b1,
    input  logic               cfg_buf_sel,
    input  logic [ADDR_W-1:0]  cfg_stride,
    input  logic [FMT_W-1:0]   cfg_fmt,
    input  logic               line_ready,
    output logic               line_valid,
    output logic [ADDR_W-1:0]  line_addr,
    output logic               line_eye,
    output logic [2:0]         color_fmt,
    output logic               stereo_en,
    output logic [DIM_W-1:0]   act_width,
    output logic [FMT_W-1:0]   act_fmt
);
    scan_state_t state_q, state_d;

    logic [ADDR_W-1:0] base_a, base_b, stride, row_off, first_base;
    logic [DIM_W-1:0]  height;
    logic              stereo, mono_eye, last_line, hs, step, zero_h;

    ssag_frame_latch #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .FMT_W(FMT_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (frame_start),
        .cfg_dims   (cfg_dims),
        .cfg_a0     (cfg_a0),
        .cfg_a1     (cfg_a1),
        .cfg_b0     (cfg_b0),
        .cfg_b1     (cfg_b1),
        .cfg_buf_sel(cfg_buf_sel),
        .cfg_stride (cfg_stride),
        .cfg_fmt    (cfg_fmt),
        .base_a     (base_a),
        .base_b     (base_b),
        .stride     (stride),
        .height     (height),
        .width      (act_width),
        .fmt        (act_fmt),
        .stereo     (stereo),
        .mono_eye   (mono_eye)
    );

    ssag_line_ctr #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_start),
        .step     (step),
        .stride   (stride),
        .height   (height),
        .row_off  (row_off),
        .last_line(last_line)
    );

    assign zero_h = (cfg_dims[2*DIM_W-1:DIM_W] == '0);
    assign hs     = line_valid & line_ready;
    assign step   = hs & !frame_start &
                    ((state_q == ST_BEAT_B) || (state_q == ST_BEAT_A && !stereo));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_WAIT:   if (line_adv) state_d = ST_BEAT_A;
            ST_BEAT_A: if (hs) state_d = stereo ? ST_BEAT_B
                                                : (last_line ? ST_IDLE : ST_WAIT);
            ST_BEAT_B: if (hs) state_d = last_line ? ST_IDLE : ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
        if (frame_start) state_d = zero_h ? ST_IDLE : ST_WAIT;
    end

    // outputs
    always_comb begin
        first_base = (!stereo && mono_eye) ? base_b : base_a;
        line_valid = (state_q == ST_BEAT_A) || (state_q == ST_BEAT_B);
        line_eye   = (state_q == ST_BEAT_B) || (!stereo && mono_eye);
        line_addr  = ((state_q == ST_BEAT_B) ? base_b : first_base) + row_off;
        color_fmt  = act_fmt[2:0];
        stereo_en  = stereo;
    end
endmodule

// File: rtl/ssag_checker.sv
module ssag_checker #(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 16,
    parameter int FMT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              line_ready,
    input logic              line_valid,
    input logic [ADDR_W-1:0] line_addr,
    input logic              line_eye,
    input logic [2:0]        color_fmt,
    input logic              stereo_en,
    input logic [DIM_W-1:0]  act_width,
    input logic [FMT_W-1:0]  act_fmt
);
    assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ready && !frame_start |=>
            line_valid && $stable(line_addr) && $stable(line_eye));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(color_fmt) && $stable(stereo_en) &&
                         $stable(act_width) && $stable(act_fmt));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !line_valid);

    assert_eye_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stereo_en && line_valid && line_ready && !line_eye && !frame_start |=>
            line_valid && line_eye);

    assert_stereo_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stereo_en |-> act_fmt[5] && !act_fmt[6]);
endmodule

bind stereo_scan_gen ssag_checker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .FMT_W(FMT_W)) i_ssag_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_ready (line_ready),
    .line_valid (line_valid),
    .line_addr  (line_addr),
    .line_eye   (line_eye),
    .color_fmt  (color_fmt),
    .stereo_en  (stereo_en),
    .act_width  (act_width),
    .act_fmt    (act_fmt)
);

// File: tb/test_stereo_scan_gen.sv
`timescale 1ns/1ps
module test_stereo_scan_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, line_adv = 1'b0, line_ready = 1'b0;
    logic [31:0] cfg_dims = '0, cfg_a0 = '0, cfg_a1 = '0, cfg_b0 = '0, cfg_b1 = '0;
    logic [31:0] cfg_stride = '0;
    logic [15:0] cfg_fmt = '0;
    logic        cfg_buf_sel = 1'b0;
    logic        line_valid, line_eye, stereo_en;
    logic [31:0] line_addr;
    logic [2:0]  color_fmt;
    logic [15:0] act_width, act_fmt;

    int vectors = 0, miscompares = 0;
    bit parity_b = 1'b0;
    logic [31:0] e_a, e_b, e_stride;
    logic [15:0] e_h, e_w, e_fmt;
    bit e_stereo, e_meye;

    always #2.5 clk = ~clk;

    stereo_scan_gen i_stereo_scan_gen (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_adv(line_adv),
        .cfg_dims(cfg_dims), .cfg_a0(cfg_a0), .cfg_a1(cfg_a1), .cfg_b0(cfg_b0),
        .cfg_b1(cfg_b1), .cfg_buf_sel(cfg_buf_sel), .cfg_stride(cfg_stride),
        .cfg_fmt(cfg_fmt), .line_ready(line_ready), .line_valid(line_valid),
        .line_addr(line_addr), .line_eye(line_eye), .color_fmt(color_fmt),
        .stereo_en(stereo_en), .act_width(act_width), .act_fmt(act_fmt));

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(logic [15:0] h, logic [15:0] w, logic [31:0] a0, logic [31:0] a1,
                           logic [31:0] b0, logic [31:0] b1, bit sel, logic [31:0] st,
                           logic [15:0] fm);
        cfg_dims = {h, w}; cfg_a0 = a0; cfg_a1 = a1; cfg_b0 = b0; cfg_b1 = b1;
        cfg_buf_sel = sel; cfg_stride = st; cfg_fmt = fm;
    endtask

    // expected captured values, from the requirements
    task automatic model_capture();
        e_a      = cfg_buf_sel ? cfg_a1 : cfg_a0;          // R3
        e_b      = cfg_buf_sel ? cfg_b1 : cfg_b0;
        e_stride = cfg_stride & 32'hFFFF_FFF8;              // R4
        e_h      = cfg_dims[31:16];
        e_w      = cfg_dims[15:0];
        e_fmt    = cfg_fmt;
        e_stereo = cfg_fmt[5] && !cfg_fmt[6];               // R6
        e_meye   = (e_a != e_b) && parity_b;                // R8
        parity_b = !parity_b;
    endtask

    task automatic scramble();
        cfg_dims = $urandom; cfg_a0 = $urandom; cfg_a1 = $urandom; cfg_b0 = $urandom;
        cfg_b1 = $urandom; cfg_stride = $urandom; cfg_fmt = 16'($urandom);
        cfg_buf_sel = 1'($urandom);
    endtask

    // called at a negedge; leaves at the negedge after capture
    task automatic start_frame(bit with_adv);
        frame_start = 1'b1;
        line_adv    = with_adv;
        model_capture();
        @(negedge clk);
        frame_start = 1'b0;
        line_adv    = 1'b0;
        chk(!line_valid, "R10", "valid after frame start", 32'(line_valid), 0);
        chk(stereo_en == e_stereo, "R6", "stereo_en", 32'(stereo_en), 32'(e_stereo));
        chk(color_fmt == e_fmt[2:0], "R11", "color_fmt", 32'(color_fmt), 32'(e_fmt[2:0]));
        chk(act_width == e_w, "R11", "act_width", 32'(act_width), 32'(e_w));
        chk(act_fmt == e_fmt, "R11", "act_fmt", 32'(act_fmt), 32'(e_fmt));
    endtask

    task automatic run_line(int n, bit rnd);
        int beats = e_stereo ? 2 : 1;
        int b = 0;
        int guard = 0;
        logic [31:0] exp_addr;
        bit exp_eye;
        line_adv = 1'b1;
        @(negedge clk);
        line_adv = 1'b0;
        while (b < beats && guard < 200) begin
            if (b == 1) begin
                exp_addr = e_b + 32'(n) * e_stride; exp_eye = 1'b1;   // R7
            end else if (e_stereo) begin
                exp_addr = e_a + 32'(n) * e_stride; exp_eye = 1'b0;   // R7
            end else begin
                exp_addr = (e_meye ? e_b : e_a) + 32'(n) * e_stride;  // R8
                exp_eye  = e_meye;
            end
            chk(line_valid, "R5", "beat valid", 32'(line_valid), 1);
            chk(line_addr == exp_addr, "R4", "line_addr", line_addr, exp_addr);
            chk(line_eye == exp_eye, "R8", "line_eye", 32'(line_eye), 32'(exp_eye));
            line_ready = rnd ? 1'($urandom) : 1'b1;
            line_adv   = rnd ? 1'($urandom) : 1'b0;   // ignored while pending (R5)
            if (line_ready) b++;
            guard++;
            @(negedge clk);
        end
        line_ready = 1'b0;
        line_adv   = 1'b0;
        chk(!line_valid, "R5", "no extra beat after line", 32'(line_valid), 0);
    endtask

    task automatic run_frame(bit rnd);
        start_frame(1'b0);
        if (rnd) scramble();                          // R2: no effect on this frame
        for (int n = 0; n < int'(e_h); n++) run_line(n, rnd);
        for (int k = 0; k < 2; k++) begin
            line_adv = 1'b1;
            @(negedge clk);
            line_adv = 1'b0;
            @(negedge clk);
            chk(!line_valid, "R5", "idle after last line", 32'(line_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5CA7_0011));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!line_valid && !stereo_en, "R1", "valid/stereo after reset",
            {30'd0, line_valid, stereo_en}, 0);
        chk(color_fmt == 0 && act_width == 0 && act_fmt == 0, "R1", "fmt/width after reset",
            {13'd0, color_fmt, act_width}, 0);
        line_adv = 1'b1; @(negedge clk); line_adv = 1'b0; @(negedge clk);
        chk(!line_valid, "R1", "advance before any frame", 32'(line_valid), 0);

        // stereo, buffer 0 (frame 0, parity even)
        set_cfg(16'd3, 16'd240, 32'h1000_0000, 32'h1100_0000, 32'h2000_0000, 32'h2100_0000,
                1'b0, 32'h0000_02D0, 16'h0022);
        run_frame(1'b0);
        // stereo, buffer 1 (R3), random stalls
        cfg_buf_sel = 1'b1;
        run_frame(1'b1);
        // bit5 & bit6 both set: stereo off (R6); bases differ: alternation (R8)
        set_cfg(16'd2, 16'd400, 32'h3000_0000, 32'h3100_0000, 32'h4000_0000, 32'h4100_0000,
                1'b0, 32'h0000_0600, 16'h0061);
        for (int f = 0; f < 3; f++) run_frame(1'b0);
        // mono, equal bases: always eye A (R8)
        cfg_b0 = cfg_a0; cfg_fmt = 16'h0003;
        for (int f = 0; f < 2; f++) run_frame(1'b0);
        // zero height (R5)
        cfg_dims = {16'd0, 16'd320};
        run_frame(1'b0);
        // stride low bits forced to zero (R4)
        set_cfg(16'd4, 16'd240, 32'h0800_0000, 32'h0, 32'h0900_0000, 32'h0, 1'b0,
                32'h0000_01E7, 16'h0024);
        run_frame(1'b0);

        // R10: frame start with line advance while a beat is stalled
        set_cfg(16'd4, 16'd240, 32'h5000_0000, 32'h0, 32'h6000_0000, 32'h0, 1'b0,
                32'h0000_0100, 16'h0020);
        start_frame(1'b0);
        line_adv = 1'b1; @(negedge clk); line_adv = 1'b0;
        chk(line_valid, "R10", "beat pending before abort", 32'(line_valid), 1);
        set_cfg(16'd2, 16'd100, 32'h7000_0000, 32'h0, 32'h7000_0000, 32'h0, 1'b0,
                32'h0000_0040, 16'h0001);
        start_frame(1'b1);
        for (int n = 0; n < 2; n++) run_line(n, 1'b0);

        // random frames
        for (int f = 0; f < 40; f++) begin
            set_cfg(16'($urandom_range(0, 5)), 16'($urandom), $urandom, $urandom,
                    ($urandom_range(0, 3) == 0) ? cfg_a0 : $urandom, $urandom,
                    1'($urandom), $urandom, 16'($urandom));
            if ($urandom_range(0, 2) == 0) cfg_fmt[6:5] = 2'b01;
            run_frame(1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule